// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Regulator

This block is the digital control for one H-bridge that feeds a single motor winding. On every clock it decides which of the four gate enables (high side and low side on each of the two legs) are on. While the winding current is rising, one diagonal pair conducts, and the direction input picks which pair. When the current comparator reports that the sensed current has reached its threshold, the bridge switches to an off configuration. It holds that configuration for a fixed number of clock cycles and then drives again.

The decay select sets which transistors stay on during the off-time. In slow decay the low-side device of the active pair stays on, so the current recirculates. In fast decay all four are off. Mixed decay starts like fast decay and switches to slow decay after a programmable number of cycles. After every off-time, after every change of direction and after each re-enable, the comparator is ignored for a blanking interval. A change of direction first turns all four gates off for a dead time. A current-level code of zero turns the bridge off.

Top module: `bridge_reg`

## Requirements
- R1: While the synchronous active-low reset is low, all four gate enables are 0 whatever the other inputs are. After reset the block stays off until a non-zero level code is seen.
- R2: In drive, direction 1 enables the A high side and the B low side, and direction 0 enables the B high side and the A low side. The enables are observed as {src_a, snk_a, src_b, snk_b} = 1001 and 0110.
- R3: A trip seen while driving ends the on phase on the next clock. The off configuration then lasts exactly OFF_CYCLES cycles, and drive resumes with the same pair. No high side is on during the off-time.
- R4: With decay select 00 (slow), only the low side of the active pair is on during the off-time (0001 for direction 1, 0100 for direction 0).
- R5: With decay select 10 or 11 (fast), all four enables are 0 for the whole off-time.
- R6: With decay select 01 (mixed), all four enables are 0 for the first FAST_CYCLES cycles of the off-time. The low side of the active pair is then on for the rest. The fast portion is clamped to OFF_CYCLES.
- R7: A blanking interval of BLANK_CYCLES cycles starts each drive phase, and trips are ignored during it. A trip held high therefore still gives one drive cycle after the interval before the next off-time.
- R8: A change of direction while enabled turns all four enables off for DEAD_CYCLES cycles. The new diagonal pair then turns on, starting with a blanking interval. One pair never follows the other directly.
- R9: A level code of 000 turns all four enables off from the next clock, and direction changes have no effect while it lasts. A non-zero code then turns on the pair for the current direction with no dead time and starts a blanking interval.
- R10: The high side and the low side of the same leg are never enabled together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip | input | 1 | Current comparator output, high when the threshold is reached |
| dir | input | 1 | Winding current direction |
| level | input | 3 | Current-level code; 000 disables the bridge |
| decay | input | 2 | Decay select: 00 slow, 01 mixed, 10/11 fast |
| src_a | output | 1 | Leg A high-side enable |
| snk_a | output | 1 | Leg A low-side enable |
| src_b | output | 1 | Leg B high-side enable |
| snk_b | output | 1 | Leg B low-side enable |

## Verification
The hardest case to reach is a trip that arrives exactly when blanking ends. The comparator has to be asserted through the whole blanking interval so that the single minimum drive cycle becomes visible. The stimulus therefore holds the trip input high from the first cycle of each blanking interval: after an off-time, after the dead time and after re-enabling. It then checks that the enables show the drive pair for exactly BLANK_CYCLES plus one cycles before the off configuration appears.

// File: rtl/bridge_reg.sv
module bridge_reg #(
  parameter int OFF_CYCLES   = 40,
  parameter int FAST_CYCLES  = 12,
  parameter int BLANK_CYCLES = 6,
  parameter int DEAD_CYCLES  = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip,
  input  logic       dir,
  input  logic [2:0] level,
  input  logic [1:0] decay,
  output logic       src_a,
  output logic       snk_a,
  output logic       src_b,
  output logic       snk_b
);
  localparam int FAST_EFF = (FAST_CYCLES > OFF_CYCLES) ? OFF_CYCLES : FAST_CYCLES;
  localparam int M1 = (OFF_CYCLES > BLANK_CYCLES) ? OFF_CYCLES : BLANK_CYCLES;
  localparam int MAXC = (M1 > DEAD_CYCLES) ? M1 : DEAD_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] OFF_LAST   = CW'(OFF_CYCLES - 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYCLES - 1);
  localparam logic [CW-1:0] DEAD_LAST  = CW'(DEAD_CYCLES - 1);
  localparam logic [CW-1:0] FAST_END   = CW'(FAST_EFF);

  localparam logic [2:0] S_DIS = 3'd0, S_DEAD = 3'd1, S_BLANK = 3'd2, S_ON = 3'd3, S_OFF = 3'd4;

  logic [2:0]    state;
  logic [CW-1:0] cnt;
  logic          dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_DIS;
      cnt   <= '0;
      dir_q <= 1'b0;
    end else if (level == 3'd0) begin
      state <= S_DIS;
      cnt   <= '0;
      dir_q <= dir;
    end else if (state != S_DIS && dir != dir_q) begin
      state <= S_DEAD;
      cnt   <= '0;
      dir_q <= dir;
    end else begin
      case (state)
        S_DIS: begin
          state <= S_BLANK;
          cnt   <= '0;
          dir_q <= dir;
        end
        S_DEAD:
          if (cnt == DEAD_LAST) begin
            state <= S_BLANK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_BLANK:
          if (cnt == BLANK_LAST) begin
            state <= S_ON;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        S_ON:
          if (trip) begin
            state <= S_OFF;
            cnt   <= '0;
          end
        S_OFF:
          if (cnt == OFF_LAST) begin
            state <= S_BLANK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        default: begin
          state <= S_DIS;
          cnt   <= '0;
        end
      endcase
    end
  end

  logic drive, sink_hold;
  assign drive     = (state == S_BLANK) || (state == S_ON);
  assign sink_hold = (state == S_OFF) &&
                     ((decay == 2'b00) || (decay == 2'b01 && cnt >= FAST_END));

  assign src_a = drive & dir_q;
  assign snk_b = (drive | sink_hold) & dir_q;
  assign src_b = drive & ~dir_q;
  assign snk_a = (drive | sink_hold) & ~dir_q;
endmodule

// File: rtl/bridge_reg_chk.sv
module bridge_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trip,
  input logic [2:0] level,
  input logic [1:0] decay,
  input logic       src_a,
  input logic       snk_a,
  input logic       src_b,
  input logic       snk_b,
  input logic [2:0] state
);
  localparam logic [2:0] C_BLANK = 3'd2, C_OFF = 3'd4;

  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> !(src_a || snk_a || src_b || snk_b));

  assert_off_no_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_OFF) |-> (!src_a && !src_b));

  assert_fast_no_sink_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_OFF && decay[1]) |-> (!snk_a && !snk_b));

  assert_blank_ignores_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_BLANK && trip) |=> (state != C_OFF));

  assert_no_swap_ab_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_a |=> !src_b);

  assert_no_swap_ba_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_b |=> !src_a);

  assert_level_zero_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (level == 3'd0) |=> !(src_a || snk_a || src_b || snk_b));

  assert_leg_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_a && snk_a) && !(src_b && snk_b));
endmodule

bind bridge_reg bridge_reg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .trip(trip), .level(level), .decay(decay),
  .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b), .state(state)
);

// File: tb/test_bridge_reg.sv
module test_bridge_reg;
  localparam int OFF = 40, FAST = 12, BLK = 6, DEAD = 250;

  logic clk = 1'b0, rst_n = 1'b0, trip = 1'b0, dir = 1'b0;
  logic [2:0] level = 3'd0;
  logic [1:0] decay = 2'b00;
  logic src_a, snk_a, src_b, snk_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bridge_reg #(.OFF_CYCLES(OFF), .FAST_CYCLES(FAST), .BLANK_CYCLES(BLK), .DEAD_CYCLES(DEAD))
    i_bridge_reg (.clk(clk), .rst_n(rst_n), .trip(trip), .dir(dir), .level(level),
                  .decay(decay), .src_a(src_a), .snk_a(snk_a), .src_b(src_b), .snk_b(snk_b));

  function automatic logic [3:0] drv(input logic d);
    return d ? 4'b1001 : 4'b0110;
  endfunction
  function automatic logic [3:0] snk(input logic d);
    return d ? 4'b0001 : 4'b0100;
  endfunction
  function automatic logic [3:0] offpat(input logic d, input logic [1:0] m, input int k);
    if (m[1]) return 4'b0000;
    if (m == 2'b01 && k <= FAST) return 4'b0000;
    return snk(d);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {src_a, snk_a, src_b, snk_b};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic t_reset;
    level = 3'd7; dir = 1'b1; trip = 1'b1;
    tick(3);
    chk("R1 reset holds off", 4'b0000);
    level = 3'd0; trip = 1'b0; rst_n = 1'b1;
    tick(3);
    chk("R1 off after reset with level 0", 4'b0000);
  endtask

  task automatic t_drive(input logic d);
    dir = d; level = 3'd7; trip = 1'b0; decay = 2'b00;
    tick(1);
    chk("R2 pair on enable", drv(d));
    tick(BLK + 5);
    chk("R2 pair held without trip", drv(d));
  endtask

  task automatic t_offtime(input logic d, input logic [1:0] m);
    string req;
    req = m[1] ? "R5" : (m == 2'b01 ? "R6" : "R4");
    decay = m; trip = 1'b1;
    tick(1);
    trip = 1'b0;
    for (int k = 1; k <= OFF; k++) begin
      chk({req, " R3 off-time pattern"}, offpat(d, m, k));
      tick(1);
    end
    chk("R3 drive resumes after off-time", drv(d));
    trip = 1'b1;
    for (int k = 1; k <= BLK; k++) begin
      chk("R7 trip ignored while blanked", drv(d));
      tick(1);
    end
    chk("R7 minimum drive cycle", drv(d));
    tick(1);
    chk("R7 trip honoured after blanking", offpat(d, m, 1));
    trip = 1'b0;
    tick(OFF + BLK + 2);
  endtask

  task automatic t_reverse;
    decay = 2'b00; trip = 1'b0; dir = 1'b0;
    tick(1);
    for (int k = 1; k <= DEAD; k++) begin
      chk("R8 dead time all off", 4'b0000);
      tick(1);
    end
    chk("R8 new pair after dead time", drv(1'b0));
    trip = 1'b1;
    tick(BLK);
    chk("R8 blanking after dead time", drv(1'b0));
    tick(1);
    chk("R8 trip after blanking", snk(1'b0));
    trip = 1'b0;
    tick(OFF + BLK + 2);
  endtask

  task automatic t_disable;
    decay = 2'b00; level = 3'd0;
    tick(1);
    chk("R9 level 000 turns off", 4'b0000);
    dir = 1'b1; trip = 1'b1;
    tick(3);
    chk("R9 stays off with dir change and trip", 4'b0000);
    level = 3'd5;
    tick(1);
    chk("R9 re-enable no dead time", drv(1'b1));
    tick(BLK);
    chk("R9 blanking after re-enable", drv(1'b1));
    tick(1);
    chk("R9 trip after blanking", snk(1'b1));
    trip = 1'b0;
    tick(OFF + BLK + 2);
    chk("R10 pair after recovery", drv(1'b1));
  endtask

  initial begin
    tick(1);
    t_reset();
    t_drive(1'b1);
    t_offtime(1'b1, 2'b00);
    t_offtime(1'b1, 2'b01);
    t_offtime(1'b1, 2'b10);
    t_offtime(1'b1, 2'b11);
    t_reverse();
    t_offtime(1'b0, 2'b00);
    t_offtime(1'b0, 2'b01);
    t_offtime(1'b0, 2'b10);
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule